// File: doc/BRIEF.md
# Serial EEPROM Slave (2-wire, 4 KiB)

This block models a 2-wire serial EEPROM that holds 4096 bytes, as a synthesizable slave. A fast system clock oversamples the bus clock and data lines. The block watches for bus START and STOP conditions and checks each device select byte against a fixed type code and three strap pins. It accepts a two-byte word address and then serves one of two operations. A write collects bytes into a page latch. A read streams bytes out of the array.

A write is committed only when the master issues a STOP. The latched page is then copied into the array and a self-timed programming window begins. For the whole window the block ignores the bus and acknowledges nothing, so a master can poll for completion by sending the device select byte until it is acknowledged. A write-protect input that is high at the STOP discards the latched page, and no programming window follows. The block only pulls SDA low, through an open-drain enable.

The controller is one state machine with these states:

- ST_IDLE waits for a START.
- ST_DEV shifts in the select byte and moves to ST_DEV_ACK on a hit. It returns to ST_IDLE on a miss.
- ST_DEV_ACK moves to ST_RDAT for a read and to ST_AHI for a write.
- ST_AHI leads through ST_AHI_ACK to ST_ALO.
- ST_ALO leads through ST_ALO_ACK to ST_WDAT.
- ST_WDAT and ST_WDAT_ACK alternate for each data byte.
- ST_RDAT shifts out eight bits and moves to ST_RACK.
- ST_RACK returns to ST_RDAT when the master acknowledges and to ST_IDLE when it does not.

A START from any state moves to ST_DEV. A STOP from any state moves to ST_IDLE.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A falling SDA while SCL is high is a START and restarts select-byte reception. A rising SDA while SCL is high is a STOP and abandons any partial byte. The STOP returns the block to idle.
- R2: The block acknowledges a select byte only when bits 7..4 equal 4'b1010 and bits 3..1 equal strap_i. Bit 0 is 1 for a read and 0 for a write. Any other select byte gets no acknowledge, and the block waits for the next START.
- R3: For every byte it accepts, the block pulls SDA low during the ninth clock and holds it low for the whole high phase of that clock.
- R4: The word address arrives high byte first. Only the low 4 bits of the high byte are used, and the upper 4 bits have no effect on the location.
- R5: During a write, the low 5 address bits advance after each data byte and wrap from 31 to 0. Address bits 11..5 stay fixed.
- R6: When a write carries more than 32 bytes, only the last 32 are stored. A later byte replaces the earlier byte at the same page offset.
- R7: A STOP that ends a write with at least one data byte commits the page and starts a programming window of PROG_CYCLES clocks. During the window no byte is acknowledged, including the block's own select byte.
- R8: If wp_i is high at the STOP, the latched bytes are discarded, the array keeps its old contents, and no programming window starts. The data bytes are still acknowledged.
- R9: A write select, a word address, a repeated START and a read select return the byte stored at that address.
- R10: A sequential read advances the full 12-bit address after each byte and rolls over from 0xFFF to 0x000.
- R11: When the master does not acknowledge a read byte, the block releases SDA and drives nothing until the next START.
- R12: In reset and straight after reset, sda_oe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 3 | Device address straps, compared with select bits 3..1 |
| wp_i | input | 1 | Write protect, sampled at STOP |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |

## Verification
The bench builds the block with ADDR_W=12 and PAGE_W=5. This keeps the full 4096-byte array, so the rollover at 0xFFF and page wrapping at real page edges can be reached. PROG_CYCLES is set to 300, which makes the programming window short enough to poll through many times. A master polls during the window to see the refused acknowledge, then after the window to see it accepted again. SYNC_STAGES stays at 2 with a bus quarter-period of six clocks, so acknowledge and read bits settle well before the master samples them.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK
    } eep_state_t;

    // Type code expected in the upper nibble of the select byte
    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/eep_line_sampler.sv
module eep_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_sh;
    logic [TOP:0] sda_sh;
    logic         scl_d;
    logic         sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[TOP-1:0], scl_i};
            sda_sh <= {sda_sh[TOP-1:0], sda_i};
            scl_d  <= scl_sh[TOP];
            sda_d  <= sda_sh[TOP];
        end
    end

    assign scl_lvl   = scl_sh[TOP];
    assign sda_lvl   = sda_sh[TOP];
    assign scl_rise  = scl_lvl & ~scl_d;
    assign scl_fall  = ~scl_lvl & scl_d;
    // Data edges with the clock held high are bus conditions, never data
    assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
    parameter int unsigned PROG_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (kick) begin
            remain <= CW'(PROG_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              lat_we,
    input  logic [ADDR_W-1:0] lat_addr,
    input  logic [7:0]        lat_data,
    input  logic              commit,
    input  logic              drop
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PAGE   = 1 << PAGE_W;
    localparam int BASE_W = ADDR_W - PAGE_W;

    logic [7:0]        mem   [DEPTH];
    logic [7:0]        latch [PAGE];
    logic [PAGE-1:0]   vld;
    logic [BASE_W-1:0] base;
    logic              copying;
    logic [PAGE_W-1:0] idx;

    assign rd_data = mem[rd_addr];

    // Control: valid flags, page base, copy sequencer (one entry per clock)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld     <= '0;
            base    <= '0;
            copying <= 1'b0;
            idx     <= '0;
        end else if (copying) begin
            vld[idx] <= 1'b0;
            idx      <= idx + 1'b1;
            if (idx == {PAGE_W{1'b1}}) begin
                copying <= 1'b0;
            end
        end else if (commit) begin
            copying <= 1'b1;
            idx     <= '0;
        end else if (drop) begin
            vld <= '0;
        end else if (lat_we) begin
            vld[lat_addr[PAGE_W-1:0]] <= 1'b1;
            base                      <= lat_addr[ADDR_W-1:PAGE_W];
        end
    end

    // Storage: no reset on latch or array contents
    always_ff @(posedge clk) begin
        if (lat_we && !copying) begin
            latch[lat_addr[PAGE_W-1:0]] <= lat_data;
        end
        if (copying && vld[idx]) begin
            mem[{base, idx}] <= latch[idx];
        end
    end

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
    import eep_pkg::*;
#(
    parameter int          ADDR_W      = 12,
    parameter int          PAGE_W      = 5,
    parameter int unsigned PROG_CYCLES = 250000,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_oe
);
    localparam int HI_W = ADDR_W - 8;

    eep_state_t        state, nstate;
    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [3:0]        bcnt;
    logic [7:0]        shreg;
    logic [7:0]        txreg;
    logic [ADDR_W-1:0] ptr;
    logic              rw;
    logic              m_ack;
    logic              wr_pending;
    logic              prog_busy;
    logic              rx_state;
    logic              byte_done;
    logic              dev_hit;
    logic              lat_we;
    logic              commit;
    logic              drop;
    logic [7:0]        rd_data;

    eep_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    eep_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .kick (commit),
        .busy (prog_busy)
    );

    eep_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (ptr),
        .rd_data (rd_data),
        .lat_we  (lat_we),
        .lat_addr(ptr),
        .lat_data(shreg),
        .commit  (commit),
        .drop    (drop)
    );

    assign rx_state  = (state == ST_DEV) || (state == ST_AHI) ||
                       (state == ST_ALO) || (state == ST_WDAT);
    assign byte_done = rx_state && scl_fall && (bcnt == 4'd8);
    assign dev_hit   = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == strap_i) && !prog_busy;
    assign lat_we    = (state == ST_WDAT) && byte_done;
    assign commit    = stop_det && wr_pending && !wp_i && !prog_busy;
    assign drop      = (start_det || stop_det) && !commit && !prog_busy;

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:     nstate = ST_IDLE;
            ST_DEV:      if (byte_done) nstate = dev_hit ? ST_DEV_ACK : ST_IDLE;
            ST_DEV_ACK:  if (scl_fall)  nstate = rw ? ST_RDAT : ST_AHI;
            ST_AHI:      if (byte_done) nstate = ST_AHI_ACK;
            ST_AHI_ACK:  if (scl_fall)  nstate = ST_ALO;
            ST_ALO:      if (byte_done) nstate = ST_ALO_ACK;
            ST_ALO_ACK:  if (scl_fall)  nstate = ST_WDAT;
            ST_WDAT:     if (byte_done) nstate = ST_WDAT_ACK;
            ST_WDAT_ACK: if (scl_fall)  nstate = ST_WDAT;
            ST_RDAT:     if (scl_fall && bcnt == 4'd7) nstate = ST_RACK;
            ST_RACK:     if (scl_fall)  nstate = m_ack ? ST_RDAT : ST_IDLE;
            default:     nstate = ST_IDLE;
        endcase
        if (start_det) begin
            nstate = ST_DEV;
        end else if (stop_det) begin
            nstate = ST_IDLE;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt       <= '0;
            shreg      <= '0;
            txreg      <= 8'hFF;
            ptr        <= '0;
            rw         <= 1'b0;
            m_ack      <= 1'b0;
            wr_pending <= 1'b0;
        end else begin
            if (start_det || state != nstate) begin
                bcnt <= '0;
            end else if (rx_state && scl_rise) begin
                bcnt <= bcnt + 1'b1;
            end else if (state == ST_RDAT && scl_fall) begin
                bcnt <= bcnt + 1'b1;
            end

            if (rx_state && scl_rise) begin
                shreg <= {shreg[6:0], sda_lvl};
            end
            if (state == ST_DEV && byte_done) begin
                rw <= shreg[0];
            end

            if (state == ST_AHI && byte_done) begin
                ptr[ADDR_W-1:8] <= shreg[HI_W-1:0];
            end else if (state == ST_ALO && byte_done) begin
                ptr[7:0] <= shreg;
            end else if (lat_we) begin
                ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
            end else if (nstate == ST_RDAT && state != ST_RDAT) begin
                ptr <= ptr + 1'b1;
            end

            if (nstate == ST_RDAT && state != ST_RDAT) begin
                txreg <= rd_data;
            end else if (state == ST_RDAT && scl_fall) begin
                txreg <= {txreg[6:0], 1'b1};
            end

            if (state == ST_RACK && scl_rise) begin
                m_ack <= ~sda_lvl;
            end

            if (start_det || stop_det) begin
                wr_pending <= 1'b0;
            end else if (lat_we) begin
                wr_pending <= 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: sda_oe = 1'b1;
            ST_RDAT:                                         sda_oe = ~txreg[7];
            default:                                         sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/eep_checker.sv
module eep_checker
    import eep_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_oe,
    input logic       prog_busy,
    input logic       wr_pending,
    input logic       wp_i,
    input logic [2:0] strap_i,
    input logic [7:0] shreg,
    input eep_state_t state
);

    // R3: the data line drive never moves while the bus clock is high
    p_ack_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !$past(start_det) && !$past(stop_det))
        |-> $stable(sda_oe));

    // R7: silent for the whole programming window
    p_busy_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> !sda_oe);

    // R7: a write ended by STOP without protection starts the window
    p_commit_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && wr_pending && !wp_i && !prog_busy) |=> prog_busy);

    // R8: protected STOP leaves the timer idle
    p_wp_no_prog_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && wr_pending && wp_i && !prog_busy) |=> !prog_busy);

    // R2: acknowledge of a select byte only on a type and strap match
    p_dev_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV_ACK) |-> (shreg[7:4] == DEV_TYPE && shreg[3:1] == strap_i));

endmodule

bind serial_eeprom_slave eep_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .prog_busy (prog_busy),
    .wr_pending(wr_pending),
    .wp_i      (wp_i),
    .strap_i   (strap_i),
    .shreg     (shreg),
    .state     (state)
);

// File: tb/sim_serial_eeprom_slave.sv
module sim_serial_eeprom_slave;

    localparam int ADDR_W = 12;
    localparam int PAGE_W = 5;
    localparam int PROG   = 300;
    localparam int Q      = 6;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_bus;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] ref_mem [DEPTH];
    bit         known   [DEPTH];
    logic [7:0] wbuf    [64];

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    serial_eeprom_slave #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG), .SYNC_STAGES(2)
    ) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_bus),
        .strap_i(STRAP),
        .wp_i   (wp),
        .sda_oe (sda_oe)
    );

    function automatic logic [7:0] sel(bit rd, logic [2:0] st, logic [3:0] ty);
        return {ty, st, rd};
    endfunction

    function automatic logic [11:0] page_slot(logic [11:0] a, int i);
        logic [4:0] lo;
        lo = a[4:0] + 5'(i);
        return {a[11:5], lo};
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(bit b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output bit b_mid, output bit b_late);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b_mid = sda_bus; tick(Q - 1);
        b_late = sda_bus; tick(1);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(logic [7:0] v, output bit ack, output bit held);
        bit m, l;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(m, l);
        ack  = !m;
        held = !m && !l;
    endtask

    task automatic recv_byte(bit give_ack, output logic [7:0] v);
        bit m, l;
        for (int i = 7; i >= 0; i--) begin
            get_bit(m, l);
            v[i] = m;
        end
        put_bit(!give_ack);
    endtask

    // Write n bytes from wbuf; junk goes into the unused high-address nibble
    task automatic write_txn(logic [11:0] a, int n, bit wpv, logic [3:0] junk, string req);
        bit ak, hd, all_ok;
        all_ok = 1'b1;
        wp = wpv;
        bus_start();
        send_byte(sel(1'b0, STRAP, 4'hA), ak, hd); all_ok &= hd;
        send_byte({junk, a[11:8]}, ak, hd);        all_ok &= hd;
        send_byte(a[7:0], ak, hd);                 all_ok &= hd;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ak, hd);
            all_ok &= hd;
        end
        bus_stop();
        tick(2);
        wp = 1'b0;
        chk(all_ok, req, int'(all_ok), 1);
        if (!wpv) begin
            for (int i = 0; i < n; i++) begin
                ref_mem[page_slot(a, i)] = wbuf[i];
                known[page_slot(a, i)]   = 1'b1;
            end
            tick(PROG + 40);
        end
    endtask

    task automatic read_txn(logic [11:0] a, int n, string req);
        bit ak, hd, all_ok, rel;
        logic [7:0] v;
        logic [11:0] p;
        all_ok = 1'b1;
        bus_start();
        send_byte(sel(1'b0, STRAP, 4'hA), ak, hd); all_ok &= ak;
        send_byte({4'h0, a[11:8]}, ak, hd);        all_ok &= ak;
        send_byte(a[7:0], ak, hd);                 all_ok &= ak;
        bus_start();
        send_byte(sel(1'b1, STRAP, 4'hA), ak, hd); all_ok &= ak;
        chk(all_ok, {req, " read setup acks"}, int'(all_ok), 1);
        p = a;
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, v);
            if (known[p]) chk(v === ref_mem[p], req, int'(v), int'(ref_mem[p]));
            p = p + 12'd1;
        end
        // R11: after the master's nack the line stays released
        rel = 1'b1;
        for (int i = 0; i < 2 * Q; i++) begin
            if (sda_oe) rel = 1'b0;
            tick(1);
        end
        chk(rel, "R11 released after nack", int'(!rel), 0);
        bus_stop();
        tick(Q);
    endtask

    task automatic fill(int n);
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        bit ak, hd;
        int unsigned seed;
        logic [11:0] ra;
        seed = $urandom(32'd2024);
        for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;

        tick(4);
        chk(sda_oe == 1'b0, "R12 reset oe", int'(sda_oe), 0);
        rst_n = 1'b1;
        tick(4);
        chk(sda_oe == 1'b0, "R12 after reset oe", int'(sda_oe), 0);

        // R2: strap mismatch, type mismatch, match
        bus_start(); send_byte(sel(1'b0, 3'b011, 4'hA), ak, hd); bus_stop();
        chk(!ak, "R2 strap mismatch nack", int'(ak), 0);
        bus_start(); send_byte(sel(1'b0, STRAP, 4'hB), ak, hd); bus_stop();
        chk(!ak, "R2 type mismatch nack", int'(ak), 0);
        bus_start(); send_byte(sel(1'b0, STRAP, 4'hA), ak, hd); bus_stop();
        chk(ak, "R2 match ack", int'(ak), 1);
        chk(hd, "R3 ack held through high", int'(hd), 1);

        // R1: partial byte aborted by STOP, then a fresh START works
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_stop();
        bus_start(); send_byte(sel(1'b0, STRAP, 4'hA), ak, hd); bus_stop();
        chk(ak, "R1 restart after aborted byte", int'(ak), 1);

        // R7: busy window refuses its own select byte
        wbuf[0] = 8'h5C;
        wp = 1'b0;
        bus_start();
        send_byte(sel(1'b0, STRAP, 4'hA), ak, hd);
        send_byte(8'h00, ak, hd);
        send_byte(8'h40, ak, hd);
        send_byte(wbuf[0], ak, hd);
        bus_stop();
        ref_mem[12'h040] = 8'h5C; known[12'h040] = 1'b1;
        tick(4);
        bus_start(); send_byte(sel(1'b0, STRAP, 4'hA), ak, hd); bus_stop();
        chk(!ak, "R7 nack while programming", int'(ak), 0);
        tick(PROG + 40);
        bus_start(); send_byte(sel(1'b0, STRAP, 4'hA), ak, hd); bus_stop();
        chk(ak, "R7 ack after window", int'(ak), 1);
        read_txn(12'h040, 1, "R7 committed byte");

        // R8: protected write acknowledged but discarded, no busy
        fill(3);
        write_txn(12'h080, 3, 1'b0, 4'h0, "R8 setup write acks");
        fill(3);
        write_txn(12'h080, 3, 1'b1, 4'h0, "R8 protected acks");
        bus_start(); send_byte(sel(1'b0, STRAP, 4'hA), ak, hd); bus_stop();
        chk(ak, "R8 no programming window", int'(ak), 1);
        read_txn(12'h080, 3, "R8 old data kept");

        // R4: junk in the upper nibble of the high address byte
        wbuf[0] = 8'hC3;
        write_txn(12'h330, 1, 1'b0, 4'hA, "R4 write acks");
        read_txn(12'h330, 1, "R4 upper nibble ignored");

        // R6: 40 bytes into one page keeps the last 32
        fill(40);
        write_txn(12'h105, 40, 1'b0, 4'h0, "R6 write acks");
        read_txn(12'h100, 32, "R6 last 32 kept");

        // R5: wrap inside the page
        fill(4);
        write_txn(12'h21E, 4, 1'b0, 4'h0, "R5 write acks");
        read_txn(12'h200, 2, "R5 wrapped bytes");
        read_txn(12'h21E, 2, "R5 first bytes");

        // R10: rollover at the top of the array
        fill(32);
        write_txn(12'hFE0, 32, 1'b0, 4'h0, "R10 write top page");
        fill(4);
        write_txn(12'h000, 4, 1'b0, 4'h0, "R10 write bottom");
        read_txn(12'hFFD, 6, "R10 rollover");

        // Random page writes, some protected
        for (int k = 0; k < 5; k++) begin
            int n;
            bit pv;
            ra = 12'($urandom);
            n  = 1 + int'($urandom % 40);
            pv = ($urandom % 4) == 0;
            fill(n);
            write_txn(ra, n, pv, 4'($urandom), "R6 random write acks");
        end

        // R9: random reads of known locations
        for (int k = 0; k < 15; k++) begin
            ra = 12'($urandom);
            for (int t = 0; t < 400 && !known[ra]; t++) ra = 12'($urandom);
            read_txn(ra, 1 + int'($urandom % 4), "R9 random read");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule